// File: doc/BRIEF.md
# Decrement execution unit with arithmetic flags

This block is the execution slice for a "subtract one" operation in a datapath that handles several operand widths. Each cycle it can accept one operation. The inputs are the raw opcode byte, the three ModRM fields, the prefix indicators and the processor-mode bit. From these the block decides whether the encoding is a decrement at all. It then picks the operand width (8, 16, 32 or 64 bits) and resolves the destination register, including the extended registers and the legacy high-byte registers.

For a legal operation the block subtracts one from the supplied operand at the chosen width. It rebuilds the overflow, sign, zero, auxiliary-carry and parity flags from that result. The carry flag and every other bit of the incoming flag word pass through unchanged. If an atomic (LOCK) prefix is used with a register destination, the block raises an invalid-opcode strobe instead of a result.

All outputs are registered. They appear one cycle after the start strobe. The caller supplies the operand already aligned to bit 0, so a high-byte register destination arrives as the byte in `dst_val[7:0]`.

Top module: `dec_exec_unit`

## Requirements
- R1: `out_result` equals the operand minus one, truncated to the selected width. Bits above that width read zero, and an operand of zero wraps to all ones at the width.
- R2: Flag word bit positions are CF=0, PF=2, AF=4, ZF=6, SF=7 and OF=11. CF and every bit other than PF, AF, ZF, SF and OF leave the block exactly as they entered.
- R3: OF is 1 exactly when the operand equals the most negative signed value of the width. SF equals the top bit of the result at the width.
- R4: ZF is 1 when the result at the width is zero. PF is 1 when the low byte of the result holds an even number of ones. AF is 1 when the low nibble of the operand is zero.
- R5: `out_size` codes are 0=8, 1=16, 2=32 and 3=64 bits. Opcode 0xFE with ModRM reg field 1 gives size 0. Opcode 0xFF with reg field 1 gives size 2 by default and size 1 with the operand-size prefix. In 64-bit mode, REX present with W set gives size 3, and this overrides the operand-size prefix.
- R6: Outside 64-bit mode, bytes 0x48–0x4F decrement register `opcode[2:0]`, with a size chosen as for 0xFF. In 64-bit mode these bytes produce neither strobe.
- R7: For a 0xFE/0xFF register destination (ModRM mod = 3), `out_reg` = {REX.B, rm} when REX is present in 64-bit mode. Outside 64-bit mode the REX inputs are ignored and `out_reg` = rm.
- R8: For an 8-bit register destination with rm 4–7 and no effective REX, `out_hi_byte`=1 and `out_reg`=rm−4. With REX present in 64-bit mode, `out_hi_byte`=0 and `out_reg`=rm.
- R9: LOCK with a register destination gives a one-cycle `out_ud` pulse with `out_valid` low, and all data outputs keep their previous values. LOCK with a memory destination (mod ≠ 3) completes normally with `out_to_mem`=1, `out_reg`=0 and `out_hi_byte`=0.
- R10: A start with any encoding that is not a decrement produces no strobe and leaves every data output unchanged. This covers 0xFE/0xFF with a reg field other than 1, and all other opcodes.
- R11: `out_valid` or `out_ud` rises exactly one cycle after an accepted start, lasts one cycle, and the two are never high together. Reset clears all outputs to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Operation present this cycle |
| opcode | input | 8 | Primary opcode byte |
| modrm_mod | input | 2 | ModRM mod field (3 = register destination) |
| modrm_reg | input | 3 | ModRM reg field (opcode extension) |
| modrm_rm | input | 3 | ModRM r/m field |
| pfx_opsize | input | 1 | Operand-size override prefix seen |
| pfx_rex | input | 1 | REX prefix present |
| pfx_rex_w | input | 1 | REX.W bit |
| pfx_rex_b | input | 1 | REX register-extension bit for r/m |
| pfx_lock | input | 1 | LOCK prefix seen |
| mode64 | input | 1 | Processor in 64-bit mode |
| dst_val | input | 64 | Destination operand, aligned to bit 0 |
| flags_in | input | FLAG_W | Incoming flag word |
| out_size | output | 2 | Decoded operand size code |
| out_reg | output | 4 | Decoded destination register index |
| out_hi_byte | output | 1 | Destination is the high byte of `out_reg` |
| out_to_mem | output | 1 | Destination is a memory operand |
| out_result | output | 64 | Decremented value, zero-extended |
| out_flags | output | FLAG_W | Updated flag word |
| out_valid | output | 1 | Result strobe |
| out_ud | output | 1 | Invalid-opcode strobe |

## Verification
The bound checker checks the following on every cycle:
- the two strobes never overlap, and a result strobe always follows a start;
- the result is the prior operand minus one at the reported size;
- CF is carried through and ZF agrees with the result;
- a LOCK never yields a result for a register destination;
- 0x48–0x4F never completes in 64-bit mode;
- the data outputs hold whenever no result is strobed.

Some behaviour depends on specific operand values and prefix combinations, so only the bench scenarios can show it:
- OF exactly at the most negative value of each width;
- AF and PF at their boundaries;
- REX.W overriding the operand-size prefix;
- REX inputs being ignored outside 64-bit mode;
- the high-byte register mapping.

// File: rtl/dec_pkg.sv
package dec_pkg;
  localparam int unsigned DATA_W    = 64;
  localparam int unsigned NUM_SIZES = 4;
  localparam int unsigned REG_IDX_W = 4;

  typedef enum logic [1:0] {
    SZ_8  = 2'd0,
    SZ_16 = 2'd1,
    SZ_32 = 2'd2,
    SZ_64 = 2'd3
  } op_size_e;

  // Flag word bit positions consumed by the neighbouring flag register
  localparam int unsigned FLG_CF = 0;
  localparam int unsigned FLG_PF = 2;
  localparam int unsigned FLG_AF = 4;
  localparam int unsigned FLG_ZF = 6;
  localparam int unsigned FLG_SF = 7;
  localparam int unsigned FLG_OF = 11;

  localparam logic [7:0] OPC_GRP_BYTE = 8'hFE;
  localparam logic [7:0] OPC_GRP_WIDE = 8'hFF;
  localparam logic [4:0] OPC_SHORT_HI = 5'b01001;
  localparam logic [2:0] GRP_SEL_DEC  = 3'd1;
  localparam logic [1:0] MOD_REG      = 2'd3;

  typedef struct packed {
    logic of_f;
    logic sf_f;
    logic zf_f;
    logic af_f;
    logic pf_f;
  } arith_flags_t;

  typedef struct packed {
    logic                 is_dec;
    logic                 to_mem;
    logic                 lock_bad;
    op_size_e             size;
    logic [REG_IDX_W-1:0] reg_idx;
    logic                 hi_byte;
  } dec_info_t;
endpackage

// File: rtl/dec_decode.sv
module dec_decode
  import dec_pkg::*;
(
  input  logic [7:0] opcode,
  input  logic [1:0] modrm_mod,
  input  logic [2:0] modrm_reg,
  input  logic [2:0] modrm_rm,
  input  logic       pfx_opsize,
  input  logic       pfx_rex,
  input  logic       pfx_rex_w,
  input  logic       pfx_rex_b,
  input  logic       pfx_lock,
  input  logic       mode64,
  output dec_info_t  info
);
  logic grp_form;
  logic short_form;
  logic rex_eff;
  logic byte_op;
  logic reg_dst;

  always_comb begin
    grp_form   = ((opcode == OPC_GRP_BYTE) || (opcode == OPC_GRP_WIDE)) &&
                 (modrm_reg == GRP_SEL_DEC);
    short_form = (opcode[7:3] == OPC_SHORT_HI) && !mode64;
    rex_eff    = mode64 && pfx_rex;
    byte_op    = (opcode == OPC_GRP_BYTE);
    reg_dst    = short_form || (modrm_mod == MOD_REG);

    info.is_dec   = grp_form || short_form;
    info.to_mem   = grp_form && (modrm_mod != MOD_REG);
    info.lock_bad = pfx_lock && reg_dst;

    // operand width: W wins over the size override
    if (byte_op)                    info.size = SZ_8;
    else if (rex_eff && pfx_rex_w)  info.size = SZ_64;
    else if (pfx_opsize)            info.size = SZ_16;
    else                            info.size = SZ_32;

    // destination register selection
    info.reg_idx = '0;
    info.hi_byte = 1'b0;
    if (short_form) begin
      info.reg_idx = {1'b0, opcode[2:0]};
    end else if (modrm_mod == MOD_REG) begin
      if (byte_op && !rex_eff && modrm_rm[2]) begin
        info.reg_idx = {2'b00, modrm_rm[1:0]};
        info.hi_byte = 1'b1;
      end else begin
        info.reg_idx = {rex_eff && pfx_rex_b, modrm_rm};
      end
    end
  end
endmodule

// File: rtl/dec_alu.sv
module dec_alu
  import dec_pkg::*;
(
  input  op_size_e          size,
  input  logic [DATA_W-1:0] dst,
  output logic [DATA_W-1:0] res,
  output arith_flags_t      fl
);
  logic [DATA_W-1:0] res_lane [NUM_SIZES];
  arith_flags_t      fl_lane  [NUM_SIZES];

  // one lane per width, all evaluated in parallel
  for (genvar g = 0; g < NUM_SIZES; g++) begin : g_lane
    localparam int unsigned W = 8 << g;
    logic [W-1:0] opnd;
    logic [W-1:0] diff;

    assign opnd = dst[W-1:0];
    assign diff = opnd - W'(1);

    assign res_lane[g]     = DATA_W'(diff);
    assign fl_lane[g].of_f = (opnd == {1'b1, {(W-1){1'b0}}});
    assign fl_lane[g].sf_f = diff[W-1];
    assign fl_lane[g].zf_f = (diff == '0);
    assign fl_lane[g].af_f = (opnd[3:0] == 4'h0);
    assign fl_lane[g].pf_f = ~^diff[7:0];
  end

  always_comb begin
    res = res_lane[size];
    fl  = fl_lane[size];
  end
endmodule

// File: rtl/dec_flag_merge.sv
module dec_flag_merge
  import dec_pkg::*;
#(
  parameter int unsigned FLAG_W = 32
) (
  input  logic [FLAG_W-1:0] flags_in,
  input  arith_flags_t      fl,
  output logic [FLAG_W-1:0] flags_out
);
  always_comb begin
    flags_out         = flags_in;
    flags_out[FLG_OF] = fl.of_f;
    flags_out[FLG_SF] = fl.sf_f;
    flags_out[FLG_ZF] = fl.zf_f;
    flags_out[FLG_AF] = fl.af_f;
    flags_out[FLG_PF] = fl.pf_f;
  end
endmodule

// File: rtl/dec_exec_unit.sv
module dec_exec_unit
  import dec_pkg::*;
#(
  parameter int unsigned FLAG_W = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [7:0]           opcode,
  input  logic [1:0]           modrm_mod,
  input  logic [2:0]           modrm_reg,
  input  logic [2:0]           modrm_rm,
  input  logic                 pfx_opsize,
  input  logic                 pfx_rex,
  input  logic                 pfx_rex_w,
  input  logic                 pfx_rex_b,
  input  logic                 pfx_lock,
  input  logic                 mode64,
  input  logic [DATA_W-1:0]    dst_val,
  input  logic [FLAG_W-1:0]    flags_in,
  output logic [1:0]           out_size,
  output logic [REG_IDX_W-1:0] out_reg,
  output logic                 out_hi_byte,
  output logic                 out_to_mem,
  output logic [DATA_W-1:0]    out_result,
  output logic [FLAG_W-1:0]    out_flags,
  output logic                 out_valid,
  output logic                 out_ud
);
  localparam int unsigned SYNC_STAGES = 2;

  // reset: asserted asynchronously, released on a clock edge
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[SYNC_STAGES-1];

  dec_info_t         info;
  logic [DATA_W-1:0] alu_res;
  arith_flags_t      alu_fl;
  logic [FLAG_W-1:0] merged_flags;

  dec_decode u_decode (
    .opcode     (opcode),
    .modrm_mod  (modrm_mod),
    .modrm_reg  (modrm_reg),
    .modrm_rm   (modrm_rm),
    .pfx_opsize (pfx_opsize),
    .pfx_rex    (pfx_rex),
    .pfx_rex_w  (pfx_rex_w),
    .pfx_rex_b  (pfx_rex_b),
    .pfx_lock   (pfx_lock),
    .mode64     (mode64),
    .info       (info)
  );

  dec_alu u_alu (
    .size (info.size),
    .dst  (dst_val),
    .res  (alu_res),
    .fl   (alu_fl)
  );

  dec_flag_merge #(.FLAG_W(FLAG_W)) u_merge (
    .flags_in  (flags_in),
    .fl        (alu_fl),
    .flags_out (merged_flags)
  );

  // next-state
  logic valid_d;
  logic ud_d;
  logic load_en;

  always_comb begin
    valid_d = start && info.is_dec && !info.lock_bad;
    ud_d    = start && info.is_dec &&  info.lock_bad;
    load_en = valid_d;
  end

  // strobe registers
  logic valid_q;
  logic ud_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      valid_q <= 1'b0;
      ud_q    <= 1'b0;
    end else begin
      valid_q <= valid_d;
      ud_q    <= ud_d;
    end
  end

  // data registers, enabled only by a completing operation
  op_size_e             size_q;
  logic [REG_IDX_W-1:0] reg_q;
  logic                 hi_q;
  logic                 mem_q;
  logic [DATA_W-1:0]    res_q;
  logic [FLAG_W-1:0]    flags_q;

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      size_q  <= SZ_8;
      reg_q   <= '0;
      hi_q    <= 1'b0;
      mem_q   <= 1'b0;
      res_q   <= '0;
      flags_q <= '0;
    end else if (load_en) begin
      size_q  <= info.size;
      reg_q   <= info.reg_idx;
      hi_q    <= info.hi_byte;
      mem_q   <= info.to_mem;
      res_q   <= alu_res;
      flags_q <= merged_flags;
    end
  end

  assign out_size    = size_q;
  assign out_reg     = reg_q;
  assign out_hi_byte = hi_q;
  assign out_to_mem  = mem_q;
  assign out_result  = res_q;
  assign out_flags   = flags_q;
  assign out_valid   = valid_q;
  assign out_ud      = ud_q;
endmodule

// File: rtl/dec_exec_unit_chk.sv
module dec_exec_unit_chk
  import dec_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [7:0]        opcode,
  input logic              pfx_lock,
  input logic              mode64,
  input logic [DATA_W-1:0] dst_val,
  input logic              cf_in,
  input logic [1:0]        out_size,
  input logic              out_to_mem,
  input logic [DATA_W-1:0] out_result,
  input logic              out_cf,
  input logic              out_zf,
  input logic              out_valid,
  input logic              out_ud
);
  function automatic logic [DATA_W-1:0] trunc(input logic [DATA_W-1:0] v,
                                              input logic [1:0] s);
    case (s)
      2'd0:    return {56'b0, v[7:0]};
      2'd1:    return {48'b0, v[15:0]};
      2'd2:    return {32'b0, v[31:0]};
      default: return v;
    endcase
  endfunction

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && out_ud)); // R11

  AST_VALID_AFTER_START: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(start)); // R11

  AST_RESULT_DEC: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_result == trunc($past(dst_val) - 64'd1, out_size)); // R1

  AST_CF_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_cf == $past(cf_in)); // R2

  AST_ZF_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_zf == (out_result == '0)); // R4

  AST_BYTE_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(opcode) == OPC_GRP_BYTE) |-> out_size == 2'd0); // R5

  AST_NO_SHORT_64: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(mode64)) |-> $past(opcode[7:3]) != OPC_SHORT_HI); // R6

  AST_LOCK_MEM_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (!$past(pfx_lock) || out_to_mem)); // R9

  AST_UD_FROM_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    out_ud |-> $past(pfx_lock)); // R9

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_result) && $stable(out_size))); // R10
endmodule

bind dec_exec_unit dec_exec_unit_chk chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .opcode     (opcode),
  .pfx_lock   (pfx_lock),
  .mode64     (mode64),
  .dst_val    (dst_val),
  .cf_in      (flags_in[dec_pkg::FLG_CF]),
  .out_size   (out_size),
  .out_to_mem (out_to_mem),
  .out_result (out_result),
  .out_cf     (out_flags[dec_pkg::FLG_CF]),
  .out_zf     (out_flags[dec_pkg::FLG_ZF]),
  .out_valid  (out_valid),
  .out_ud     (out_ud)
);

// File: tb/dec_exec_unit_tb_top.sv
module dec_exec_unit_tb_top;
  localparam int FW = 32;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  opcode;
  logic [1:0]  modrm_mod;
  logic [2:0]  modrm_reg;
  logic [2:0]  modrm_rm;
  logic        pfx_opsize, pfx_rex, pfx_rex_w, pfx_rex_b, pfx_lock, mode64;
  logic [63:0] dst_val;
  logic [FW-1:0] flags_in;

  logic [1:0]  out_size;
  logic [3:0]  out_reg;
  logic        out_hi_byte, out_to_mem, out_valid, out_ud;
  logic [63:0] out_result;
  logic [FW-1:0] out_flags;

  always #2 clk = ~clk;

  dec_exec_unit #(.FLAG_W(FW)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
    .modrm_mod(modrm_mod), .modrm_reg(modrm_reg), .modrm_rm(modrm_rm),
    .pfx_opsize(pfx_opsize), .pfx_rex(pfx_rex), .pfx_rex_w(pfx_rex_w),
    .pfx_rex_b(pfx_rex_b), .pfx_lock(pfx_lock), .mode64(mode64),
    .dst_val(dst_val), .flags_in(flags_in),
    .out_size(out_size), .out_reg(out_reg), .out_hi_byte(out_hi_byte),
    .out_to_mem(out_to_mem), .out_result(out_result), .out_flags(out_flags),
    .out_valid(out_valid), .out_ud(out_ud)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    done    = 0;
  string cur_req = "R11";

  // reference model state
  bit          m_valid, m_ud, m_hi, m_mem;
  int          m_size;
  int          m_reg;
  bit [63:0]   m_res;
  bit [FW-1:0] m_flags;

  task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, act, exp);
    end
  endtask

  // behavioural model: computes the state expected after the next edge
  task automatic model_step();
    bit is_dec, short_f, rex_on, reg_dst;
    int width, ones;
    bit [63:0] mask, op, res;
    m_valid = 0;
    m_ud    = 0;
    if (!start || !rst_n) return;
    short_f = (opcode >= 8'h48 && opcode <= 8'h4F) && !mode64;
    is_dec  = short_f || ((opcode == 8'hFE || opcode == 8'hFF) && modrm_reg == 3'd1);
    if (!is_dec) return;
    reg_dst = short_f || modrm_mod == 2'd3;
    if (pfx_lock && reg_dst) begin
      m_ud = 1;
      return;
    end
    rex_on = mode64 && pfx_rex;
    if (opcode == 8'hFE)          width = 8;
    else if (rex_on && pfx_rex_w) width = 64;
    else if (pfx_opsize)          width = 16;
    else                          width = 32;
    case (width)
      8:       m_size = 0;
      16:      m_size = 1;
      32:      m_size = 2;
      default: m_size = 3;
    endcase
    mask = (width == 64) ? '1 : ((64'd1 << width) - 64'd1);
    op   = dst_val & mask;
    res  = (op - 64'd1) & mask;
    ones = 0;
    for (int i = 0; i < 8; i++) ones += int'(res[i]);
    m_res        = res;
    m_flags      = flags_in;
    m_flags[11]  = (op == (64'd1 << (width - 1)));
    m_flags[7]   = res[width-1];
    m_flags[6]   = (res == 64'd0);
    m_flags[4]   = (op[3:0] == 4'd0);
    m_flags[2]   = (ones % 2 == 0);
    m_valid      = 1;
    m_mem        = !reg_dst;
    m_hi         = 0;
    if (short_f)                   m_reg = int'(opcode) - 8'h48;
    else if (!reg_dst)             m_reg = 0;
    else if (width == 8 && !rex_on && modrm_rm >= 3'd4) begin
      m_reg = int'(modrm_rm) - 4;
      m_hi  = 1;
    end else                       m_reg = int'(modrm_rm) + ((rex_on && pfx_rex_b) ? 8 : 0);
  endtask

  task automatic tick();
    model_step();
    @(posedge clk);
    @(negedge clk);
    chk("out_valid",   64'(out_valid),   64'(m_valid));
    chk("out_ud",      64'(out_ud),      64'(m_ud));
    chk("out_size",    64'(out_size),    64'(m_size));
    chk("out_reg",     64'(out_reg),     64'(m_reg));
    chk("out_hi_byte", 64'(out_hi_byte), 64'(m_hi));
    chk("out_to_mem",  64'(out_to_mem),  64'(m_mem));
    chk("out_result",  out_result,       m_res);
    chk("out_flags",   64'(out_flags),   64'(m_flags));
  endtask

  task automatic run_op(input logic [7:0] opc, input logic [1:0] md,
                        input logic [2:0] rg, input logic [2:0] rm,
                        input logic osz, input logic rx, input logic rw,
                        input logic rb, input logic lk, input logic m64,
                        input logic [63:0] v, input logic [FW-1:0] f);
    start = 1; opcode = opc; modrm_mod = md; modrm_reg = rg; modrm_rm = rm;
    pfx_opsize = osz; pfx_rex = rx; pfx_rex_w = rw; pfx_rex_b = rb;
    pfx_lock = lk; mode64 = m64; dst_val = v; flags_in = f;
    tick();
    start = 0;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    m_valid = 0; m_ud = 0; m_hi = 0; m_mem = 0; m_size = 0; m_reg = 0;
    m_res = '0; m_flags = '0;
    start = 0; opcode = 8'h90; modrm_mod = 0; modrm_reg = 0; modrm_rm = 0;
    pfx_opsize = 0; pfx_rex = 0; pfx_rex_w = 0; pfx_rex_b = 0; pfx_lock = 0;
    mode64 = 0; dst_val = '0; flags_in = '0;
    rst_n = 1'b1;
    #1 rst_n = 1'b0;
    @(negedge clk);
    cur_req = "R11 reset";
    tick(); tick();
    rst_n = 1'b1;
    tick(); tick(); tick();

    // 8-bit corner values
    cur_req = "R1 R3 R4 byte wrap";
    run_op(8'hFE, 2'd3, 3'd1, 3'd0, 0, 0, 0, 0, 0, 0, 64'hFFFF_FF00, 32'h0);
    cur_req = "R3 byte OF";
    run_op(8'hFE, 2'd3, 3'd1, 3'd1, 0, 0, 0, 0, 0, 0, 64'h80, 32'h0);
    cur_req = "R4 byte ZF";
    run_op(8'hFE, 2'd3, 3'd1, 3'd2, 0, 0, 0, 0, 0, 0, 64'h01, 32'h0);
    cur_req = "R4 AF PF";
    run_op(8'hFE, 2'd3, 3'd1, 3'd3, 0, 0, 0, 0, 0, 0, 64'h10, 32'h0);
    cur_req = "R2 flags passthrough set";
    run_op(8'hFE, 2'd3, 3'd1, 3'd3, 0, 0, 0, 0, 0, 0, 64'h37, 32'hFFFF_FFFF);
    cur_req = "R2 flags passthrough clear";
    run_op(8'hFE, 2'd3, 3'd1, 3'd3, 0, 0, 0, 0, 0, 0, 64'h00, 32'hFFFF_F7FE);

    // width selection
    cur_req = "R5 default 32";
    run_op(8'hFF, 2'd3, 3'd1, 3'd6, 0, 0, 0, 0, 0, 0, 64'hAAAA_8000_0000, 32'h1);
    cur_req = "R5 opsize 16";
    run_op(8'hFF, 2'd3, 3'd1, 3'd6, 1, 0, 0, 0, 0, 0, 64'h1234_8000, 32'h0);
    cur_req = "R5 R3 REX.W 64";
    run_op(8'hFF, 2'd3, 3'd1, 3'd2, 0, 1, 1, 0, 0, 1, 64'h8000_0000_0000_0000, 32'h1);
    cur_req = "R5 REX.W beats opsize";
    run_op(8'hFF, 2'd3, 3'd1, 3'd2, 1, 1, 1, 0, 0, 1, 64'h0, 32'h0);
    cur_req = "R5 mode64 default 32";
    run_op(8'hFF, 2'd3, 3'd1, 3'd2, 0, 0, 0, 0, 0, 1, 64'hFFFF_FFFF_0000_0001, 32'h0);

    // short register form
    cur_req = "R6 short form legacy";
    run_op(8'h4D, 2'd0, 3'd0, 3'd0, 0, 0, 0, 0, 0, 0, 64'h0000_0100, 32'h0);
    cur_req = "R6 short form 16";
    run_op(8'h48, 2'd0, 3'd0, 3'd0, 1, 0, 0, 0, 0, 0, 64'h0, 32'h1);
    cur_req = "R6 short form in mode64 ignored";
    run_op(8'h4B, 2'd0, 3'd1, 3'd0, 0, 0, 0, 0, 0, 1, 64'h55, 32'h0);

    // register index
    cur_req = "R7 REX.B extension";
    run_op(8'hFF, 2'd3, 3'd1, 3'd5, 0, 1, 0, 1, 0, 1, 64'h9, 32'h0);
    cur_req = "R7 REX ignored outside mode64";
    run_op(8'hFF, 2'd3, 3'd1, 3'd5, 0, 1, 1, 1, 0, 0, 64'h1_0000_0000, 32'h0);
    cur_req = "R8 high byte legacy";
    run_op(8'hFE, 2'd3, 3'd1, 3'd7, 0, 0, 0, 0, 0, 1, 64'h42, 32'h0);
    cur_req = "R8 REX low byte";
    run_op(8'hFE, 2'd3, 3'd1, 3'd4, 0, 1, 0, 0, 0, 1, 64'h42, 32'h0);

    // LOCK handling
    cur_req = "R9 lock register ud";
    run_op(8'hFE, 2'd3, 3'd1, 3'd1, 0, 0, 0, 0, 1, 0, 64'h77, 32'hF);
    cur_req = "R9 lock short form ud";
    run_op(8'h49, 2'd0, 3'd0, 3'd0, 0, 0, 0, 0, 1, 0, 64'h77, 32'hF);
    cur_req = "R9 lock memory ok";
    run_op(8'hFF, 2'd1, 3'd1, 3'd6, 0, 0, 0, 0, 1, 0, 64'h0, 32'h0);

    // not a decrement
    cur_req = "R10 FE reg0";
    run_op(8'hFE, 2'd3, 3'd0, 3'd1, 0, 0, 0, 0, 0, 0, 64'h5, 32'h3);
    cur_req = "R10 FF reg2";
    run_op(8'hFF, 2'd3, 3'd2, 3'd1, 0, 0, 0, 0, 0, 0, 64'h5, 32'h3);
    cur_req = "R10 other opcode";
    run_op(8'h40, 2'd3, 3'd1, 3'd1, 0, 0, 0, 0, 0, 0, 64'h5, 32'h3);

    // back-to-back then idle
    cur_req = "R11 back to back";
    run_op(8'hFE, 2'd3, 3'd1, 3'd0, 0, 0, 0, 0, 0, 0, 64'h3, 32'h0);
    run_op(8'hFE, 2'd3, 3'd1, 3'd0, 0, 0, 0, 0, 0, 0, 64'h2, 32'h0);
    cur_req = "R11 idle";
    tick(); tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule